// File: doc/BRIEF.md
# Prescaled Periodic Timer with Interrupt Latch

This block combines a programmable periodic timer with a small latch of interrupt flags. Two 16-bit configuration values, a prescale value P and a divide value D, set a reload count of (P+1)*(D+1) clock cycles. The count runs down one step per cycle and reloads itself at the end. If either value is zero, the timer stops and its count is held at zero. Each time the count runs out, the timer raises its pending flag in the latch.

The latch keeps one pending flag and one enable bit for each interrupt source. The timer owns one source index. The remaining sources are driven by single-cycle event pulses from outside the block. The interrupt output is high while any source has both its flag and its enable set. It stays high until the software clears the responsible flags by writing ones to the clear field of the control word. The same control word write also replaces the enable bits.

Top module: `tick_irq_unit`

## Requirements
- R1: A write with `wr_sel`=0 (prescale) or `wr_sel`=1 (divide) stores `wr_data` and, on the same edge, loads `count_val` with (P+1)*(D+1) computed from the updated values. The full product (up to 2^32) is kept without truncation.
- R2: While P or D is zero, `count_val` reads 0 and the timer sets no pending flag.
- R3: While running, `count_val` falls by one per cycle. On the edge where it equals 1, the timer pending flag (source 3) is set and the count reloads. The first timer event therefore lands exactly (P+1)*(D+1) cycles after the loading write.
- R4: Without further configuration writes, later timer events repeat every (P+1)*(D+1) cycles.
- R5: `irq` is high exactly while some source n has both pending flag n and enable n set. Masking a source keeps its flag set but keeps `irq` low.
- R6: A write with `wr_sel`=2 (control) loads enable n from `wr_data[n]` and clears pending flag n wherever `wr_data[8+n]` is 1.
- R7: A 0 in clear bit `wr_data[8+n]` leaves pending flag n unchanged.
- R8: An event for source n in the same cycle as a clear of flag n leaves the flag set.
- R9: `ext_evt[n]` sets pending flag n on the edge where it is high. `ext_evt[3]` is ignored because source 3 belongs to the timer.
- R10: `status_word[7:0]` holds the pending flags (bit n = source n, timer at bit 3, source 4 at bit 4). `status_word[15:8]` holds the enables in the same order.
- R11: After reset, all flags, enables, both configuration values and the count are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 prescale, 1 divide, 2 control, 3 none |
| wr_data | input | 16 | Write data |
| ext_evt | input | 5 | Event pulses, one per source (bit 3 unused) |
| status_word | output | 16 | Enables in the high byte, pending flags in the low byte |
| count_val | output | 33 | Current timer count |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted count shows up on `count_val` in the very next cycle. It also shows up as a timer flag arriving in the wrong cycle, which the bench times exactly against the arithmetic product for every small prescale and divide pair. A latch flag that is lost, set twice or cleared wrongly shows up in `status_word` one edge after the offending event or control write. A wrong enable or a wrong mask combination shows up on `irq` in that same cycle.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

  // Targets for a register write
  typedef enum logic [1:0] {
    SEL_PRESCALE = 2'd0,
    SEL_DIVIDE   = 2'd1,
    SEL_CONTROL  = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;

  // Flag update over an 8-bit lane: new events take priority over clears
  function automatic logic [7:0] flag_step(input logic [7:0] cur,
                                           input logic [7:0] clr,
                                           input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_pre,
  input  logic              load_div,
  input  logic [PW-1:0]     wr_val,
  output logic [2*PW:0]     count,
  output logic              fire
);
  localparam int CW = 2*PW + 1;

  // Reload length; zero in either operand means stopped
  function automatic logic [CW-1:0] span(input logic [PW-1:0] p,
                                         input logic [PW-1:0] d);
    logic [CW-1:0] pw, dw;
    if (p == '0 || d == '0) return '0;
    pw = CW'(p) + CW'(1);
    dw = CW'(d) + CW'(1);
    return pw * dw;
  endfunction

  logic [PW-1:0] pre_q, div_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pre_nx, div_nx;
  logic          cfg_off;
  logic          load_any;
  logic [CW-1:0] period_now;

  assign pre_nx     = load_pre ? wr_val : pre_q;
  assign div_nx     = load_div ? wr_val : div_q;
  assign load_any   = load_pre | load_div;
  assign cfg_off    = (pre_q == '0) || (div_q == '0);
  assign period_now = span(pre_q, div_q);
  assign fire       = !cfg_off && (cnt_q == CW'(1));
  assign count      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_nx;
      div_q <= div_nx;
      if (load_any)      cnt_q <= span(pre_nx, div_nx);
      else if (cfg_off)  cnt_q <= '0;
      else if (fire)     cnt_q <= period_now;
      else               cnt_q <= cnt_q - CW'(1);
    end
  end

  // R2: stopped timer holds a zero count
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_off && !load_any) |=> (cnt_q == '0));

  // R3: expiry reloads the full period
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load_any) |=> (cnt_q == $past(period_now)));

  // R3: running count steps down by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_off && !fire && !load_any) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R1: a running count stays inside one period
  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_off |-> (cnt_q != '0 && cnt_q <= period_now));

endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import tick_irq_pkg::*;
#(
  parameter int NSRC    = 5,
  parameter int TMR_IDX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic [15:0]     ctrl_data,
  input  logic [NSRC-1:0] ext_evt,
  input  logic            tmr_fire,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] en,
  output logic            irq
);
  logic [NSRC-1:0] pend_q, en_q;
  logic [NSRC-1:0] set_vec, clr_vec;
  logic [7:0]      cur8, clr8, set8, nxt8;

  // Per-source event and clear selection
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == TMR_IDX) begin : g_tmr
      assign set_vec[i] = tmr_fire;
    end else begin : g_ext
      assign set_vec[i] = ext_evt[i];
    end
    assign clr_vec[i] = ctrl_wr & ctrl_data[8+i];
  end

  always_comb begin
    cur8 = '0; clr8 = '0; set8 = '0;
    cur8[NSRC-1:0] = pend_q;
    clr8[NSRC-1:0] = clr_vec;
    set8[NSRC-1:0] = set_vec;
    nxt8 = flag_step(cur8, clr8, set8);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= nxt8[NSRC-1:0];
      if (ctrl_wr) en_q <= ctrl_data[NSRC-1:0];
    end
  end

  assign pend = pend_q;
  assign en   = en_q;
  assign irq  = |(pend_q & en_q);

  // R8: every event lands, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R6: cleared flags without a new event drop
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  // R7: without a control write no flag is lost
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R5: the request only drops after a control write
  a_r5_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ctrl_wr));

endmodule

// File: rtl/tick_irq_unit.sv
module tick_irq_unit
  import tick_irq_pkg::*;
#(
  parameter int PW      = 16,
  parameter int NSRC    = 5,
  parameter int TMR_IDX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [15:0]     wr_data,
  input  logic [NSRC-1:0] ext_evt,
  output logic [15:0]     status_word,
  output logic [2*PW:0]   count_val,
  output logic            irq
);
  logic            load_pre, load_div, ctrl_wr;
  logic            tmr_fire;
  logic [NSRC-1:0] pend, en;

  assign load_pre = wr_en && (reg_sel_e'(wr_sel) == SEL_PRESCALE);
  assign load_div = wr_en && (reg_sel_e'(wr_sel) == SEL_DIVIDE);
  assign ctrl_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_CONTROL);

  tick_divider #(.PW(PW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_pre (load_pre),
    .load_div (load_div),
    .wr_val   (wr_data[PW-1:0]),
    .count    (count_val),
    .fire     (tmr_fire)
  );

  irq_latch #(.NSRC(NSRC), .TMR_IDX(TMR_IDX)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_data (wr_data),
    .ext_evt   (ext_evt),
    .tmr_fire  (tmr_fire),
    .pend      (pend),
    .en        (en),
    .irq       (irq)
  );

  always_comb begin
    status_word = '0;
    status_word[NSRC-1:0] = pend;
    status_word[8 +: NSRC] = en;
  end

  // R9: the timer flag only rises on a timer expiry
  a_r9_timer_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_fire && !pend[TMR_IDX]) |=> !pend[TMR_IDX]);

endmodule

// File: tb/tick_irq_unit_test.sv
module tick_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [15:0] wr_data = '0;
  logic [4:0]  ext_evt = '0;
  logic [15:0] status_word;
  logic [32:0] count_val;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  tick_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ext_evt(ext_evt), .status_word(status_word),
    .count_val(count_val), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint unsigned per;
    int t;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk("R11 status", status_word, 0);
    chk("R11 count", count_val, 0);
    chk("R11 irq", irq, 0);

    // R6/R10 enable timer source
    wr(2'd2, 16'h0008);
    chk("R10 enable byte", status_word, 16'h0800);

    // Sweep small prescale/divide values
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 4; d++) begin
        wr(2'd0, 16'(p));
        wr(2'd1, 16'(d));
        per = (p == 0 || d == 0) ? 0 : longint'(p + 1) * longint'(d + 1);
        chk("R1 load", count_val, per);
        if (per == 0) begin
          repeat (20) tick();
          chk("R2 count held", count_val, 0);
          chk("R2 no flag", status_word[3], 0);
        end else begin
          t = 0;
          while (!status_word[3] && t < 200) begin tick(); t++; end
          chk("R3 first event", t, per);
          chk("R5 irq up", irq, 1);
          wr(2'd2, 16'h0808); t++;
          chk("R6 cleared", status_word[3], 0);
          while (!status_word[3] && t < 400) begin tick(); t++; end
          chk("R4 period", t, 2 * per);
          wr(2'd2, 16'h0808);
        end
      end
    end

    // R5 masking
    wr(2'd2, 16'h0800);
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd1);
    repeat (4) tick();
    chk("R5 masked flag", status_word[3], 1);
    chk("R5 masked irq", irq, 0);
    wr(2'd2, 16'h0008);
    chk("R7 flag kept", status_word[3], 1);
    chk("R5 unmasked irq", irq, 1);
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h1F00);
    chk("R6 clear all", status_word, 16'h0000);

    // External events
    ext_evt = 5'b00001; tick(); ext_evt = '0;
    chk("R9 source 0", status_word[7:0], 8'h01);
    chk("R5 no enable irq", irq, 0);
    ext_evt = 5'b01000; tick(); ext_evt = '0;
    chk("R9 timer index ignored", status_word[3], 0);
    ext_evt = 5'b10000; tick(); ext_evt = '0;
    chk("R10 source 4 bit", status_word[7:0], 8'h11);
    wr(2'd2, 16'h0011);
    chk("R7 zero clears", status_word, 16'h1111);
    chk("R5 irq ext", irq, 1);
    wr(2'd2, 16'h0111);
    chk("R6 clear source 0", status_word[7:0], 8'h10);
    ext_evt = 5'b10000;
    wr(2'd2, 16'h1011);
    ext_evt = '0;
    chk("R8 event wins", status_word[4], 1);
    wr(2'd2, 16'h1011);
    chk("R6 clear source 4", status_word[7:0], 8'h00);
    chk("R5 irq drop", irq, 0);

    // Restart on write
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd2);
    repeat (3) tick();
    chk("R3 countdown", count_val, 6);
    wr(2'd0, 16'd4);
    chk("R1 restart", count_val, 15);

    // Widest product
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'hFFFF);
    chk("R1 full width", count_val, 64'h1_0000_0000);
    tick();
    chk("R3 wide step", count_val, 64'hFFFF_FFFF);
    wr(2'd1, 16'd0);
    chk("R2 stop", count_val, 0);
    repeat (5) tick();
    chk("R2 stay", count_val, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule